// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block is the configuration front end of an I/O-mapped peripheral controller. It answers at two neighbouring byte addresses on a single-host I/O bus. The lower address is the index port and the next one up is the data port. A strap input picks which of two base addresses is used. Out of reset the port is locked. The host opens it by writing the open key 0x87 to the index port on two writes in a row. Writing the close key 0xAA to the index port locks it again.

While the port is open, the host writes a register number to the index port and then reads or writes that register through the data port. The block itself holds four kinds of register: a logical-device select register, a read-only 16-bit device identifier, a revision byte and a read-only 16-bit vendor identifier. Every register number from 0x30 upward belongs to the selected logical device. Accesses to those numbers are passed on through a strobe interface that carries the device number, the register number and the write data. The device answers a read one cycle after its strobe.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, the index register holds 0x00 and the device select register holds 0x00.
- R2: While the port is not open, a read of either port returns 0xFF. Data-port writes change no register and raise no device strobe.
- R3: The port opens only after two consecutive index-port writes of 0x87. Any other index-port write after a single 0x87 returns the sequence to its start.
- R4: An index-port write of 0xAA while the port is open locks it. The index register keeps its value for the next opening.
- R5: While the port is open, any index-port write other than 0xAA loads the index register, and an index-port read returns it.
- R6: Register 0x07 is the device select register. A data-port write to it sets the device number and a data-port read returns it.
- R7: Registers 0x20 and 0x21 return the high and low bytes of the device identifier. Register 0x22 returns the revision byte. Registers 0x23 and 0x24 return the vendor identifier 0x1934, high byte first (0x19, then 0x34).
- R8: Writes to the identifier and revision registers have no effect. A register number below 0x30 that is not listed above reads as 0xFF.
- R9: A data-port read with index 0x30 or above raises `dev_rd` for exactly that cycle, with `dev_num` equal to the selected device and `dev_idx` equal to the index. The byte on `dev_rdata` in the next cycle is returned as the read result.
- R10: A data-port write with index 0x30 or above raises `dev_wr` for exactly that cycle, carrying the device number, the index and the written byte.
- R11: The index port is at the base address and the data port at base+1. The base is 0x2E when `strap_alt` is 0 and 0x4E when it is 1. Accesses to any other address have no effect and get no response.
- R12: `io_rvalid` is high exactly in the cycle after a read strobe to either port, and `io_rdata` holds the result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base select strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read result, valid while io_rvalid is high |
| io_rvalid | output | 1 | Read result valid, one cycle after a decoded read |
| dev_rd | output | 1 | Read strobe to the logical devices |
| dev_wr | output | 1 | Write strobe to the logical devices |
| dev_num | output | 8 | Selected logical device number |
| dev_idx | output | 8 | Register number inside the device |
| dev_wdata | output | 8 | Write byte to the device |
| dev_rdata | input | 8 | Device read data, due the cycle after dev_rd |

## Verification
A wrong lock state shows up on the very next read of either port. The read returns 0xFF where a register value was due, or the reverse, and a device strobe appears or goes missing in the same cycle as the host access. A corrupted index or device select register shows up on the next data-port read: the wrong local byte comes back, or the forwarded access carries the wrong `dev_num`/`dev_idx`. The bench's device model folds both of those fields into the data it returns, so such an error reaches the port in the cycle right after the read. A broken key sequence is caught by reading the data port between and after the key bytes.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } lock_st_e;

  localparam logic [DW-1:0] KEY_OPEN    = 8'h87;
  localparam logic [DW-1:0] KEY_CLOSE   = 8'hAA;
  localparam logic [DW-1:0] IX_LDSEL    = 8'h07;
  localparam logic [DW-1:0] IX_ID_HI    = 8'h20;
  localparam logic [DW-1:0] IX_ID_LO    = 8'h21;
  localparam logic [DW-1:0] IX_REV      = 8'h22;
  localparam logic [DW-1:0] IX_VEN_HI   = 8'h23;
  localparam logic [DW-1:0] IX_VEN_LO   = 8'h24;
  localparam logic [DW-1:0] IX_FWD_BASE = 8'h30;
  localparam logic [DW-1:0] RD_IDLE     = 8'hFF;
endpackage

// File: rtl/cfgp_lock_fsm.sv
module cfgp_lock_fsm
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] key_byte,
  output logic          open
);
  lock_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      case (state_q)
        ST_LOCKED: state_d = (key_byte == KEY_OPEN) ? ST_ARMED : ST_LOCKED;
        ST_ARMED:  state_d = (key_byte == KEY_OPEN) ? ST_OPEN  : ST_LOCKED;
        ST_OPEN:   state_d = (key_byte == KEY_CLOSE) ? ST_LOCKED : ST_OPEN;
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  assign open = (state_q == ST_OPEN);

  // R3
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(key_wr && key_byte == KEY_OPEN));

  // R4
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open && key_wr && key_byte == KEY_CLOSE) |=> !open);
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'h0A51,
  parameter logic [15:0] VEN_ID = 16'h1934,
  parameter logic [7:0]  REV    = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open,
  input  logic          idx_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] ldn_q,
  output logic [DW-1:0] local_rdata,
  output logic          is_local
);
  logic          idx_en, ldn_en;
  logic [DW-1:0] idx_d, ldn_d;

  always_comb begin
    idx_en = open && idx_wr && (wdata != KEY_CLOSE);
    ldn_en = open && dat_wr && (idx_q == IX_LDSEL);
    idx_d  = idx_en ? wdata : idx_q;
    ldn_d  = ldn_en ? wdata : ldn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      idx_q <= idx_d;
      ldn_q <= ldn_d;
    end
  end

  always_comb begin
    is_local = (idx_q < IX_FWD_BASE);
    case (idx_q)
      IX_LDSEL:  local_rdata = ldn_q;
      IX_ID_HI:  local_rdata = DEV_ID[15:8];
      IX_ID_LO:  local_rdata = DEV_ID[7:0];
      IX_REV:    local_rdata = REV;
      IX_VEN_HI: local_rdata = VEN_ID[15:8];
      IX_VEN_LO: local_rdata = VEN_ID[7:0];
      default:   local_rdata = RD_IDLE;
    endcase
  end

  // R6
  ldn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(open && dat_wr) |=> $stable(ldn_q));

  // R2
  idx_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(idx_q));
endmodule

// File: rtl/cfgp_fwd.sv
module cfgp_fwd
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open,
  input  logic          idx_rd,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] idx_q,
  input  logic [DW-1:0] ldn_q,
  input  logic [DW-1:0] local_rdata,
  input  logic          is_local,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [DW-1:0] dev_num,
  output logic [DW-1:0] dev_idx,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_rvalid
);
  logic          rd_any;
  logic          rvalid_q, fwd_q;
  logic          rvalid_d, fwd_d;
  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    dev_rd    = open && dat_rd && !is_local;
    dev_wr    = open && dat_wr && !is_local;
    dev_num   = ldn_q;
    dev_idx   = idx_q;
    dev_wdata = wdata;
    rd_any    = idx_rd || dat_rd;
    rvalid_d  = rd_any;
    fwd_d     = dev_rd;
    hold_d    = hold_q;
    if (rd_any) begin
      if (!open)      hold_d = RD_IDLE;
      else if (idx_rd) hold_d = idx_q;
      else            hold_d = local_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      fwd_q    <= 1'b0;
      hold_q   <= RD_IDLE;
    end else begin
      rvalid_q <= rvalid_d;
      fwd_q    <= fwd_d;
      if (rd_any) hold_q <= hold_d;
    end
  end

  assign io_rvalid = rvalid_q;
  assign io_rdata  = fwd_q ? dev_rdata : hold_q;

  // R9
  fwd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |=> (io_rvalid && fwd_q));

  // R12
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(idx_rd || dat_rd));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_rd && dat_wr) |-> $onehot0({dev_rd, dev_wr}));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfgp_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E,
  parameter logic [15:0] DEV_ID   = 16'h0A51,
  parameter logic [15:0] VEN_ID   = 16'h1934,
  parameter logic [7:0]  REV      = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic              io_rvalid,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [DW-1:0]     dev_num,
  output logic [DW-1:0]     dev_idx,
  output logic [DW-1:0]     dev_wdata,
  input  logic [DW-1:0]     dev_rdata
);
  localparam logic [ADDR_W-1:0] IDX_PRI = ADDR_W'(BASE_PRI);
  localparam logic [ADDR_W-1:0] IDX_ALT = ADDR_W'(BASE_ALT);

  logic [ADDR_W-1:0] base;
  logic              idx_hit, dat_hit;
  logic              idx_wr, idx_rd, dat_wr, dat_rd;
  logic              open, is_local;
  logic [DW-1:0]     idx_q, ldn_q, local_rdata;

  always_comb begin
    base    = strap_alt ? IDX_ALT : IDX_PRI;
    idx_hit = (io_addr == base);
    dat_hit = (io_addr == base + ADDR_W'(1));
    idx_wr  = io_wr && idx_hit;
    idx_rd  = io_rd && idx_hit;
    dat_wr  = io_wr && dat_hit;
    dat_rd  = io_rd && dat_hit;
  end

  cfgp_lock_fsm u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (idx_wr),
    .key_byte (io_wdata),
    .open     (open)
  );

  cfgp_regs #(
    .DEV_ID (DEV_ID),
    .VEN_ID (VEN_ID),
    .REV    (REV)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .open        (open),
    .idx_wr      (idx_wr),
    .dat_wr      (dat_wr),
    .wdata       (io_wdata),
    .idx_q       (idx_q),
    .ldn_q       (ldn_q),
    .local_rdata (local_rdata),
    .is_local    (is_local)
  );

  cfgp_fwd u_fwd (
    .clk         (clk),
    .rst_n       (rst_n),
    .open        (open),
    .idx_rd      (idx_rd),
    .dat_rd      (dat_rd),
    .dat_wr      (dat_wr),
    .wdata       (io_wdata),
    .idx_q       (idx_q),
    .ldn_q       (ldn_q),
    .local_rdata (local_rdata),
    .is_local    (is_local),
    .dev_rd      (dev_rd),
    .dev_wr      (dev_wr),
    .dev_num     (dev_num),
    .dev_idx     (dev_idx),
    .dev_wdata   (dev_wdata),
    .dev_rdata   (dev_rdata),
    .io_rdata    (io_rdata),
    .io_rvalid   (io_rvalid)
  );

  // R11
  no_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !idx_hit && !dat_hit) |=> !io_rvalid);
endmodule

// File: tb/test_keyed_cfg_port.sv
module test_keyed_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        dev_rd, dev_wr;
  logic [7:0]  dev_num, dev_idx, dev_wdata;
  logic [7:0]  dev_rdata = 8'h0;

  always #4 clk = ~clk;

  keyed_cfg_port i_keyed_cfg_port (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_num(dev_num), .dev_idx(dev_idx),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit rd_issued = 0;
  bit last_issued = 0;
  logic [7:0]  exp_rq[$];
  string       tag_rq[$];
  logic [15:0] exp_dq[$];
  logic [23:0] exp_wq[$];
  logic [7:0]  ldn_m = 8'h00;
  logic [15:0] base_m = 16'h002E;

  function automatic logic [7:0] model(input logic [7:0] n, input logic [7:0] ix);
    return {n[3:0], 4'h0} ^ ix ^ 8'h5A;
  endfunction

  // bench device: answers one cycle after its strobe
  always @(posedge clk) if (dev_rd) dev_rdata <= model(dev_num, dev_idx);

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // monitor: samples 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        chk(io_rvalid == last_issued, "R12 rvalid timing", io_rvalid, last_issued);
        if (io_rvalid) begin
          if (exp_rq.size() == 0)
            chk(0, "R11 unexpected read response", io_rdata, 8'hxx);
          else begin
            logic [7:0] e;
            string t;
            e = exp_rq.pop_front();
            t = tag_rq.pop_front();
            chk(io_rdata == e, t, io_rdata, e);
          end
        end
        if (dev_rd) begin
          if (exp_dq.size() == 0) chk(0, "R2 R9 unexpected dev_rd", {dev_num, dev_idx}, 0);
          else begin
            logic [15:0] e;
            e = exp_dq.pop_front();
            chk({dev_num, dev_idx} == e, "R9 dev_rd fields", {dev_num, dev_idx}, e);
          end
        end
        if (dev_wr) begin
          if (exp_wq.size() == 0) chk(0, "R2 R10 unexpected dev_wr", {dev_num, dev_idx, dev_wdata}, 0);
          else begin
            logic [23:0] e;
            e = exp_wq.pop_front();
            chk({dev_num, dev_idx, dev_wdata} == e, "R10 dev_wr fields", {dev_num, dev_idx, dev_wdata}, e);
          end
        end
      end
      last_issued = rd_issued;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input bit fwd, input logic [7:0] ix, input string t);
    exp_rq.push_back(e);
    tag_rq.push_back(t);
    if (fwd) exp_dq.push_back({ldn_m, ix});
    @(negedge clk);
    io_addr = a; io_rd = 1'b1; rd_issued = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; rd_issued = 1'b0;
  endtask

  task automatic rd_none(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic do_reset(input bit alt);
    @(negedge clk);
    rst_n = 1'b0; strap_alt = alt;
    base_m = alt ? 16'h004E : 16'h002E;
    ldn_m = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    do_reset(1'b0);
    // R2: locked reads give 0xFF, locked data writes do nothing
    rd(16'h2F, 8'hFF, 0, 0, "R2 locked data read");
    rd(16'h2E, 8'hFF, 0, 0, "R2 locked index read");
    wr(16'h2F, 8'h55);
    // R3: an interrupted key sequence does not open
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h12); wr(16'h2E, 8'h87);
    rd(16'h2F, 8'hFF, 0, 0, "R3 armed not open");
    wr(16'h2E, 8'h87);
    // R1 R5: reset index and select values
    rd(16'h2E, 8'h00, 0, 0, "R1 R5 index after reset");
    rd(16'h2F, 8'hFF, 0, 0, "R8 undefined local index 0x00");
    wr(16'h2E, 8'h07);
    rd(16'h2F, 8'h00, 0, 0, "R1 select after reset");
    // R6
    wr(16'h2F, 8'h06); ldn_m = 8'h06;
    rd(16'h2F, 8'h06, 0, 0, "R6 select readback");
    rd(16'h2E, 8'h07, 0, 0, "R5 index readback");
    // R7
    wr(16'h2E, 8'h20); rd(16'h2F, 8'h0A, 0, 0, "R7 device id high");
    wr(16'h2E, 8'h21); rd(16'h2F, 8'h51, 0, 0, "R7 device id low");
    wr(16'h2E, 8'h22); rd(16'h2F, 8'h03, 0, 0, "R7 revision");
    wr(16'h2E, 8'h23); rd(16'h2F, 8'h19, 0, 0, "R7 vendor id high");
    wr(16'h2E, 8'h24); rd(16'h2F, 8'h34, 0, 0, "R7 vendor id low");
    // R8: identifier not writable
    wr(16'h2E, 8'h21); wr(16'h2F, 8'h00);
    rd(16'h2F, 8'h51, 0, 0, "R8 id write ignored");
    wr(16'h2E, 8'h2F); rd(16'h2F, 8'hFF, 0, 0, "R8 undefined local index 0x2F");
    // R9 R10: forwarding
    wr(16'h2E, 8'h30); rd(16'h2F, model(8'h06, 8'h30), 1, 8'h30, "R9 forwarded read 0x30");
    wr(16'h2E, 8'hF1);
    exp_wq.push_back({8'h06, 8'hF1, 8'hA5});
    wr(16'h2F, 8'hA5);
    rd(16'h2F, model(8'h06, 8'hF1), 1, 8'hF1, "R9 forwarded read 0xF1");
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h07); ldn_m = 8'h07;
    wr(16'h2E, 8'hE0); rd(16'h2F, model(8'h07, 8'hE0), 1, 8'hE0, "R9 forwarded read other device");
    // R11: other addresses ignored
    wr(16'h4E, 8'h21); wr(16'h4F, 8'h33); rd_none(16'h4F); rd_none(16'h30);
    rd(16'h2F, model(8'h07, 8'hE0), 1, 8'hE0, "R11 index unchanged by foreign address");
    // R4: lock
    wr(16'h2E, 8'hAA);
    rd(16'h2F, 8'hFF, 0, 0, "R4 locked data read");
    rd(16'h2E, 8'hFF, 0, 0, "R4 locked index read");
    wr(16'h2F, 8'h99);
    // R3: close key between open keys resets sequence
    wr(16'h2E, 8'h87); wr(16'h2E, 8'hAA); wr(16'h2E, 8'h87);
    rd(16'h2F, 8'hFF, 0, 0, "R3 close key breaks sequence");
    wr(16'h2E, 8'h87);
    rd(16'h2E, 8'hE0, 0, 0, "R4 index kept across lock");
    wr(16'h2E, 8'h07);
    rd(16'h2F, 8'h07, 0, 0, "R2 select untouched while locked");
    // R11: alternate base
    do_reset(1'b1);
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87); rd_none(16'h2E);
    rd(16'h4F, 8'hFF, 0, 0, "R11 alt base still locked");
    wr(16'h4E, 8'h87); wr(16'h4E, 8'h87);
    rd(16'h4E, 8'h00, 0, 0, "R11 R1 alt base index");
    wr(16'h4E, 8'h24);
    rd(16'h4F, 8'h34, 0, 0, "R11 R7 alt base vendor low");
    repeat (4) @(negedge clk);
    chk(exp_rq.size() == 0, "R12 missing read responses", exp_rq.size(), 0);
    chk(exp_dq.size() == 0, "R9 missing dev_rd", exp_dq.size(), 0);
    chk(exp_wq.size() == 0, "R10 missing dev_wr", exp_wq.size(), 0);
    finish_run();
  end
endmodule